// File: doc/BRIEF.md
# I2C Bit-Level Line Sequencer

This block carries out one I2C bus bit at a time: a start condition, a stop condition, one written data bit or one read data bit. A byte-level controller above it issues one command per bit. The block walks each command through four timed slices (A, B, C, D) before it returns to its resting slice, IDLE. A 16-bit prescale value sets how many system clocks each slice lasts.

Both bus lines are open-drain. Each line has a pad output that is always driven 0 and an active-high output-enable-bar. When the enable-bar is high, the line floats and the external pull-up takes it high. The block reads SCL and SDA back from the pad inputs. This lets it share a wired bus with other masters, and it lets a slave stretch the clock by holding SCL low.

Commands arrive on a valid/ready interface. `cmd_ready` is high only while the engine sits in IDLE. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While the engine is busy, the source must keep the command pending; this is the back-pressure rule. Completion is a one-cycle `done` pulse. For a read, the sampled bit is available on `rd_bit` from that pulse onward.

Top module: `i2c_bit_engine`

## Requirements
- R1: `cmd_ready` is high only while no command is in progress.
  - A command is taken when `cmd_valid` and `cmd_ready` are both high at a rising clock edge. After that edge `cmd_ready` stays low until `done` has pulsed.
  - With `cmd_valid` low, the engine starts nothing: the line enables do not change and `done` stays low.
- R2: With no clock stretching, `done` goes high exactly 4*(prescale+1) clock edges after the accepting edge. Each slice A to D lasts prescale+1 clocks.
- R3: Start (`cmd_code`=0) drives the lines as {SCL, SDA} enable-bar values:
  - slice A: {unchanged, 1}
  - slice B: {1, 1}
  - slice C: {1, 0}
  - slice D: {0, 0}
- R4: Stop (`cmd_code`=1) drives the lines as {SCL, SDA} enable-bar values:
  - slice A: {unchanged, 0}
  - slices B and C: {1, 0}
  - slice D: {1, 1}
- R5: Write bit (`cmd_code`=2) holds the SDA enable-bar at `cmd_wbit` through slices A to D. SCL is low in A and D and released in B and C. SDA never changes while SCL is released.
- R6: Read bit (`cmd_code`=3) releases SDA in every slice and drives SCL as a write does. At the end of slice B, `rd_bit` takes the SDA pad input.
- R7: While the SCL enable-bar is high but `scl_i` reads low, the slice timer stands still. Each such clock adds one clock to the command.
- R8: `done` lasts exactly one clock. `rd_bit` keeps its value through any command other than a read.
- R9: After reset:
  - `cmd_ready` is 1 and `done` is 0.
  - Both enable-bars are 1, so both lines are released.
- R10: `scl_o` and `sda_o` are always 0. A line's level is set only through its enable-bar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prescale | input | 16 | Clocks per slice minus one; change only while idle |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 2 | 0 start, 1 stop, 2 write bit, 3 read bit |
| cmd_wbit | input | 1 | Bit value for a write command |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| done | output | 1 | One-clock pulse at the end of slice D |
| rd_bit | output | 1 | Last bit sampled by a read command |
| scl_i | input | 1 | SCL pad input |
| scl_o | output | 1 | SCL pad output value (always 0) |
| scl_oe_n | output | 1 | SCL enable-bar, 1 releases the line |
| sda_i | input | 1 | SDA pad input |
| sda_o | output | 1 | SDA pad output value (always 0) |
| sda_oe_n | output | 1 | SDA enable-bar, 1 releases the line |

## Verification
The bench sweeps several prescale values, including zero. For each one it runs every command and both write values, and does reads of both slave bit values. A counter that reloads off by one would move `done` away from 4*(prescale+1) edges, and at prescale zero it would show up as a stuck or doubled slice. The bench checks the enable-bars at the start of every slice. This catches a start or stop whose SDA edge lands in the wrong slice, and a write that moves SDA while SCL is high. A held SCL for a set number of clocks must add exactly that many clocks: a timer that ignores the pad would finish early, and one that also freezes while SCL is driven low would finish late.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;
  typedef enum logic [1:0] {
    BC_START = 2'd0,
    BC_STOP  = 2'd1,
    BC_WRITE = 2'd2,
    BC_READ  = 2'd3
  } bit_cmd_e;

  typedef enum logic [2:0] {
    SL_IDLE = 3'd0,
    SL_A    = 3'd1,
    SL_B    = 3'd2,
    SL_C    = 3'd3,
    SL_D    = 3'd4
  } slice_e;

  // Enable-bar values of the two lines: 1 = released (pulled high)
  typedef struct packed {
    logic scl;
    logic sda;
  } lines_t;

  function automatic slice_e slice_after(slice_e s);
    case (s)
      SL_A:    return SL_B;
      SL_B:    return SL_C;
      SL_C:    return SL_D;
      default: return SL_IDLE;
    endcase
  endfunction

  // Line state to apply on entry to slice s
  function automatic lines_t slice_lines(bit_cmd_e c, logic w, slice_e s, lines_t cur);
    lines_t r;
    r = cur;
    case (c)
      BC_START: begin
        case (s)
          SL_A:    r.sda = 1'b1;
          SL_B:    begin r.scl = 1'b1; r.sda = 1'b1; end
          SL_C:    begin r.scl = 1'b1; r.sda = 1'b0; end
          SL_D:    begin r.scl = 1'b0; r.sda = 1'b0; end
          default: r = cur;
        endcase
      end
      BC_STOP: begin
        case (s)
          SL_A:    r.sda = 1'b0;
          SL_B:    begin r.scl = 1'b1; r.sda = 1'b0; end
          SL_C:    begin r.scl = 1'b1; r.sda = 1'b0; end
          SL_D:    begin r.scl = 1'b1; r.sda = 1'b1; end
          default: r = cur;
        endcase
      end
      default: begin
        // data bit: read releases SDA, write drives the bit value
        r.sda = (c == BC_READ) ? 1'b1 : w;
        case (s)
          SL_B, SL_C: r.scl = 1'b1;
          SL_A, SL_D: r.scl = 1'b0;
          default:    r = cur;
        endcase
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/i2c_bit_slice_timer.sv
module i2c_bit_slice_timer #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             active,
  input  logic             hold,
  input  logic [PRE_W-1:0] prescale,
  output logic             slice_end
);
  logic [PRE_W-1:0] cnt_q;

  assign slice_end = active && !hold && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= prescale;
    end else if (active && !hold) begin
      if (cnt_q == '0) cnt_q <= prescale;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/i2c_bit_sequencer.sv
module i2c_bit_sequencer
  import i2c_bit_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] cmd_code,
  input  logic       cmd_wbit,
  input  logic       slice_end,
  input  logic       sda_i,
  output logic       active,
  output lines_t     lines,
  output logic       rd_bit,
  output logic       done
);
  slice_e   slice_q;
  bit_cmd_e cmd_q;
  logic     wbit_q;
  slice_e   slice_nx;

  assign active   = (slice_q != SL_IDLE);
  assign slice_nx = slice_after(slice_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slice_q <= SL_IDLE;
      cmd_q   <= BC_START;
      wbit_q  <= 1'b0;
      lines   <= '{scl: 1'b1, sda: 1'b1};
      rd_bit  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        cmd_q   <= bit_cmd_e'(cmd_code);
        wbit_q  <= cmd_wbit;
        slice_q <= SL_A;
        lines   <= slice_lines(bit_cmd_e'(cmd_code), cmd_wbit, SL_A, lines);
      end else if (slice_end) begin
        if (slice_q == SL_B && cmd_q == BC_READ) rd_bit <= sda_i;
        if (slice_q == SL_D) begin
          slice_q <= SL_IDLE;
          done    <= 1'b1;
        end else begin
          slice_q <= slice_nx;
          lines   <= slice_lines(cmd_q, wbit_q, slice_nx, lines);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_bit_pkg::*;
#(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] prescale,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_code,
  input  logic             cmd_wbit,
  output logic             cmd_ready,
  output logic             done,
  output logic             rd_bit,
  input  logic             scl_i,
  output logic             scl_o,
  output logic             scl_oe_n,
  input  logic             sda_i,
  output logic             sda_o,
  output logic             sda_oe_n
);
  logic   active;
  logic   accept;
  logic   hold;
  logic   slice_end;
  lines_t lines;

  assign cmd_ready = !active;
  assign accept    = cmd_valid && cmd_ready;
  // Released SCL that still reads low: a slave is stretching the clock
  assign hold      = lines.scl && !scl_i;

  i2c_bit_slice_timer #(.PRE_W(PRE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .active   (active),
    .hold     (hold),
    .prescale (prescale),
    .slice_end(slice_end)
  );

  i2c_bit_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .cmd_code (cmd_code),
    .cmd_wbit (cmd_wbit),
    .slice_end(slice_end),
    .sda_i    (sda_i),
    .active   (active),
    .lines    (lines),
    .rd_bit   (rd_bit),
    .done     (done)
  );

  assign scl_o    = 1'b0;
  assign sda_o    = 1'b0;
  assign scl_oe_n = lines.scl;
  assign sda_oe_n = lines.sda;
endmodule

// File: rtl/i2c_bit_engine_checker.sv
module i2c_bit_engine_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       cmd_ready,
  input logic       done,
  input logic       scl_i,
  input logic       scl_oe_n,
  input logic       sda_oe_n
);
  logic [1:0] cur_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cur_cmd <= 2'd0;
    else if (cmd_valid && cmd_ready) cur_cmd <= cmd_code;
  end

  // R1: a taken command makes the engine busy on the next cycle
  assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R8: completion is a single-cycle pulse
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: during a start, SDA falls only while SCL is released
  assert_start_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cur_cmd == 2'd0 && $fell(sda_oe_n)) |-> scl_oe_n);

  // R4: during a stop, SDA rises only while SCL is released
  assert_stop_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cur_cmd == 2'd1 && $rose(sda_oe_n)) |-> scl_oe_n);

  // R5: data bits keep SDA steady while SCL stays released
  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cur_cmd[1] && scl_oe_n && $past(scl_oe_n)) |-> $stable(sda_oe_n));

  // R7: a stretched clock cycle can never complete the command
  assert_stretch_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && scl_oe_n && !scl_i) |=> !done);
endmodule

bind i2c_bit_engine i2c_bit_engine_checker u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .cmd_ready(cmd_ready),
  .done     (done),
  .scl_i    (scl_i),
  .scl_oe_n (scl_oe_n),
  .sda_oe_n (sda_oe_n)
);

// File: tb/i2c_bit_engine_bench.sv
`timescale 1ns/1ps
module i2c_bit_engine_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] prescale = 16'd0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_code = 2'd0;
  logic        cmd_wbit = 1'b0;
  logic        cmd_ready, done, rd_bit;
  logic        scl_o, scl_oe_n, sda_o, sda_oe_n;
  logic        stretch_low = 1'b0;
  logic        slave_sda = 1'b1;
  logic        scl_i, sda_i;

  // wired-AND bus with pull-ups
  assign scl_i = scl_oe_n & ~stretch_low;
  assign sda_i = sda_oe_n & slave_sda;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic ph_scl [4];
  logic ph_sda [4];
  int   n_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bit_engine u_i2c_bit_engine (
    .clk(clk), .rst_n(rst_n), .prescale(prescale),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_wbit(cmd_wbit),
    .cmd_ready(cmd_ready), .done(done), .rd_bit(rd_bit),
    .scl_i(scl_i), .scl_o(scl_o), .scl_oe_n(scl_oe_n),
    .sda_i(sda_i), .sda_o(sda_o), .sda_oe_n(sda_oe_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected {scl, sda} enable-bars per slice k (0..3 = A..D)
  function automatic logic [1:0] exp_lines(int code, bit w, int k, bit prev_scl);
    logic [3:0] scl_pat, sda_pat;
    case (code)
      0: begin scl_pat = {1'b0, 1'b1, 1'b1, prev_scl}; sda_pat = 4'b0011; end
      1: begin scl_pat = {1'b1, 1'b1, 1'b1, prev_scl}; sda_pat = 4'b1000; end
      2: begin scl_pat = 4'b0110; sda_pat = {4{w}}; end
      default: begin scl_pat = 4'b0110; sda_pat = 4'b1111; end
    endcase
    return {scl_pat[k], sda_pat[k]};
  endfunction

  task automatic run_cmd(input int code, input bit w, input int stretch);
    int scnt;
    scnt = 0;
    stretch_low = (stretch > 0);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = code[1:0];
    cmd_wbit  = w;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n_done = -1;
    for (int i = 0; i < 2000; i++) begin
      if (stretch_low && scl_oe_n) begin
        if (scnt == stretch) stretch_low = 1'b0;
        else scnt++;
      end
      if (i % (prescale + 1) == 0 && i < 4 * (prescale + 1)) begin
        ph_scl[i / (prescale + 1)] = scl_oe_n;
        ph_sda[i / (prescale + 1)] = sda_oe_n;
      end
      if (i == 1) chk(cmd_ready == 1'b0, "R1 busy ready", cmd_ready, 0);
      if (done) begin n_done = i; break; end
      @(posedge clk);
      @(negedge clk);
    end
    stretch_low = 1'b0;
    chk(cmd_ready == 1'b1, "R1 ready after done", cmd_ready, 1);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    chk(scl_o == 1'b0 && sda_o == 1'b0, "R10 pad outputs low", {scl_o, sda_o}, 0);
  endtask

  task automatic check_phases(input int code, input bit w, input bit prev_scl, input string req);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] e;
      e = exp_lines(code, w, k, prev_scl);
      chk({ph_scl[k], ph_sda[k]} == e, req, {ph_scl[k], ph_sda[k]}, e);
    end
    chk(n_done == 4 * (prescale + 1), "R2 command length", n_done, 4 * (prescale + 1));
  endtask

  initial begin
    int plist [5] = '{0, 1, 2, 3, 5};
    bit prev;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(cmd_ready == 1'b1 && done == 1'b0, "R9 reset handshake", {cmd_ready, done}, 2);
    chk(scl_oe_n && sda_oe_n, "R9 reset lines released", {scl_oe_n, sda_oe_n}, 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: nothing starts without cmd_valid
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || !scl_oe_n || !sda_oe_n || !cmd_ready)
        chk(1'b0, "R1 idle no activity", {done, scl_oe_n, sda_oe_n, cmd_ready}, 7);
    end
    chk(scl_oe_n && sda_oe_n && cmd_ready, "R1 idle lines held", {scl_oe_n, sda_oe_n}, 3);

    foreach (plist[p]) begin
      prescale = plist[p][15:0];
      prev = 1'b1;
      run_cmd(0, 1'b0, 0);
      check_phases(0, 1'b0, prev, "R3 start slices");
      prev = 1'b0;
      for (int w = 0; w < 2; w++) begin
        logic keep;
        keep = rd_bit;
        run_cmd(2, w[0], 0);
        check_phases(2, w[0], prev, "R5 write slices");
        chk(rd_bit == keep, "R8 rd_bit kept over write", rd_bit, keep);
      end
      for (int b = 0; b < 2; b++) begin
        slave_sda = b[0];
        run_cmd(3, 1'b0, 0);
        slave_sda = 1'b1;
        check_phases(3, 1'b0, prev, "R6 read slices");
        chk(rd_bit == b[0], "R6 read sample", rd_bit, b);
      end
      run_cmd(1, 1'b0, 0);
      check_phases(1, 1'b0, prev, "R4 stop slices");
    end

    // R7: clock stretching lengthens the command clock for clock
    prescale = 16'd2;
    run_cmd(0, 1'b0, 0);
    for (int s = 1; s < 8; s += 3) begin
      run_cmd(2, 1'b1, s);
      chk(n_done == 4 * 3 + s, "R7 stretch length", n_done, 4 * 3 + s);
    end
    run_cmd(1, 1'b0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule